// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

The block is a first-in first-out buffer that sits between two unrelated clock domains. Words of 9 bits enter on the write clock and leave on the read clock. The storage depth is a power-of-two parameter, 16 by default. Write and read pointers cross between the domains as Gray codes through two-flop synchronizers. Besides the full and empty indications it drives three active-low status flags:

- an almost-full flag, with a loadable full offset m;
- an almost-empty flag, with a loadable empty offset n;
- a half-full flag, which the write clock sets and the read clock clears.

A mode input is sampled while reset is held. In standard mode a read strobe moves the next word onto the data output. In first-word-fall-through mode the head word is placed on the output without any strobe. That output register acts as one extra word of storage, so the effective depth becomes D+1 and every flag threshold moves by one word as seen from the ports. Both offsets return to their default on reset. The default is 7 for depths below 64 and a parameter otherwise. Software can rewrite the offsets only while the write side sees the FIFO empty and no write is happening in that cycle.

Top module: `dcf_fifo`

## Requirements
- R1: While rst_n is low and at the first sampling after it is released: full_n=1, paf_n=1, hf_n=1, empty_n=0, pae_n=0 and dout=0.
- R2: In standard mode (fwft_sel=0 during reset), a rising read-clock edge with rd_en=1 and empty_n=1 places the oldest stored word on dout. Words come out in write order.
- R3: In first-word-fall-through mode (fwft_sel=1 during reset), the head word appears on dout with empty_n=1 a few read clocks after it was written, with no rd_en. empty_n stays high until a read-clock edge with rd_en=1 finds no further word to present.
- R4: paf_n goes low on the write-clock edge of the write that makes the stored count reach D-m. With no reads this is D-m writes in standard mode and D+1-m writes in first-word-fall-through mode.
- R5: pae_n is updated on read-clock edges. It is low while the FIFO holds n words or fewer in standard mode, and n+1 words or fewer in first-word-fall-through mode.
- R6: hf_n goes low on the write-clock edge that brings the count above D/2. With no reads this is D/2+1 writes in standard mode and D/2+2 writes in first-word-fall-through mode. hf_n goes high on the read-clock edge that brings the count to D/2 or less, before the write side has seen that read. It goes low again on the next write that crosses the half-way mark.
- R7: full_n goes low once D words are stored (D+1 in first-word-fall-through mode). A write while full_n=0 is dropped, and the stored sequence is unchanged.
- R8: A read while the FIFO is empty is ignored. dout keeps its value, and the next word written is the next word read.
- R9: After reset both offsets equal 7 (at the default depth of 16). A load with ofs_ld=1 takes effect only in a write-clock cycle where the write side sees the FIFO empty and wr_en=0. Loaded offsets must be below D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several edges of both clocks |
| fwft_sel | input | 1 | Read mode sampled during reset: 0 standard, 1 first-word-fall-through |
| wr_en | input | 1 | Write strobe (write clock) |
| din | input | 9 | Write data |
| full_n | output | 1 | Low when no more words fit |
| paf_n | output | 1 | Almost-full flag, active low, write clock |
| rd_en | input | 1 | Read strobe (read clock) |
| dout | output | 9 | Read data |
| empty_n | output | 1 | Standard mode: word available. First-word-fall-through mode: dout valid |
| pae_n | output | 1 | Almost-empty flag, active low, read clock |
| hf_n | output | 1 | Half-full flag, active low, driven from both domains |
| ofs_ld | input | 1 | Offset load request (write clock) |
| ofs_full_in | input | log2(D)+1 | New full offset m |
| ofs_empty_in | input | log2(D)+1 | New empty offset n |

## Verification
Two of the block's functions can meet in the same write-clock cycle: an offset load and a write. The bench asserts both on one edge and then judges by where paf_n falls. If it falls after the default D-7 writes, the load was refused. If it falls after D-3 writes, the load was wrongly accepted. The half-full flag also has two owners that can be pending together. The bench pushes the count just above D/2 and then reads one word before the write side has synchronized that read. It expects hf_n high on the next write-clock sample, and low again on the following crossing write.

// File: rtl/dcf_pkg.sv
// Shared types and helpers for the dual-clock FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dcf_pkg;
    // Read-side presentation modes, latched while reset is held.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Default threshold offset used for both m and n after reset.
    function automatic int unsigned dflt_offset(input int unsigned depth,
                                                input int unsigned big_ofs);
        return (depth < 64) ? 32'd7 : big_ofs;
    endfunction
endpackage

// File: rtl/dcf_ptr_xing.sv
// Moves a binary pointer from one clock domain into another.
// The pointer is registered as Gray code in the source domain, passed
// through two flops in the destination domain and decoded back to binary.
// Assumes the source value changes by at most one per source clock.
module dcf_ptr_xing #(
    parameter int PW = 5
) (
    input  logic          src_clk,
    input  logic          dst_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_bin,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] gray_q;
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Register the Gray form so only one bit toggles per source edge.
    always_ff @(posedge src_clk) begin
        if (!rst_n) gray_q <= '0;
        else        gray_q <= src_bin ^ (src_bin >> 1);
    end

    // Two-stage synchronizer into the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_q;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the parity of all bits at or above it.
    assign dst_bin[PW-1] = sync_q[PW-1];
    for (genvar i = 0; i < PW-1; i++) begin : g_g2b
        assign dst_bin[i] = ^sync_q[PW-1:i];
    end
endmodule

// File: rtl/dcf_ram.sv
// Storage array: one synchronous write port on the write clock and one
// combinational read port addressed by the read side.
// Assumes DEPTH is a power of two and small enough for registers.
module dcf_ram #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Capture a word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_offsets.sv
// Holds the full offset m and the empty offset n in the write domain.
// Both reset to the default value. A load is accepted only when the
// write side reports the FIFO idle. The empty offset is used by the read
// side as a quasi-static value, because it only changes while nothing is stored.
module dcf_offsets #(
    parameter int DEPTH   = 16,
    parameter int BIG_OFS = 127,
    localparam int PW     = $clog2(DEPTH) + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic          idle,
    input  logic [PW-1:0] full_in,
    input  logic [PW-1:0] empty_in,
    output logic [PW-1:0] full_ofs,
    output logic [PW-1:0] empty_ofs
);
    localparam logic [PW-1:0] DFLT = PW'(dcf_pkg::dflt_offset(DEPTH, BIG_OFS));

    // Restore defaults on reset, accept a load only while idle.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            full_ofs  <= DFLT;
            empty_ofs <= DFLT;
        end else if (ld && idle) begin
            full_ofs  <= full_in;
            empty_ofs <= empty_in;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: write pointer, full, almost-full and the
// write half of the half-full flag (an "over half" level plus an epoch
// bit that toggles on each upward crossing).
// Counts are RAM occupancy: write pointer minus synchronized read pointer.
// Assumes the full offset is below DEPTH.
module dcf_wr_side #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] r_bin_s,
    input  logic [PW-1:0] full_ofs,
    output logic [PW-1:0] w_bin,
    output logic          w_accept,
    output logic          w_idle,
    output logic          full_n,
    output logic          paf_n,
    output logic          w_over,
    output logic          w_epoch
);
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    logic [PW-1:0] w_bin_nxt;
    logic [PW-1:0] wcnt_nxt;
    logic [PW:0]   paf_sum;

    // Next pointer and occupancy as they will be after this edge.
    always_comb begin
        w_accept  = wr_en && full_n;
        w_bin_nxt = w_bin + {{(PW-1){1'b0}}, w_accept};
        wcnt_nxt  = w_bin_nxt - r_bin_s;
        paf_sum   = {1'b0, wcnt_nxt} + {1'b0, full_ofs};
        w_idle    = (w_bin == r_bin_s) && !wr_en;
    end

    // Pointer and registered write-domain flags.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            w_bin   <= '0;
            full_n  <= 1'b1;
            paf_n   <= 1'b1;
            w_over  <= 1'b0;
            w_epoch <= 1'b0;
        end else begin
            w_bin  <= w_bin_nxt;
            full_n <= (wcnt_nxt != FULL_CNT);
            paf_n  <= !(paf_sum >= {1'b0, FULL_CNT});
            w_over <= (wcnt_nxt > HALF_CNT);
            if (!w_over && (wcnt_nxt > HALF_CNT)) w_epoch <= !w_epoch;
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: read pointer, output register, empty/valid,
// almost-empty and the read half of the half-full flag.
// In standard mode a strobe pops a word into dout. In fall-through mode
// dout is refilled whenever it is vacant or being consumed.
// Flags use RAM occupancy only. The output register supplies the extra
// word of depth in fall-through mode.
module dcf_rd_side #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic          rd_en,
    input  logic [PW-1:0] w_bin_s,
    input  logic          w_epoch_s,
    input  logic [PW-1:0] empty_ofs,
    input  logic [DW-1:0] ram_q,
    output logic [PW-1:0] r_bin,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          pae_n,
    output logic          r_drop,
    output logic          r_epoch,
    output logic          is_fwft
);
    import dcf_pkg::*;

    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

    rd_mode_e      mode_q;
    logic          ram_empty_q;
    logic          ov_q;
    logic          pop;
    logic [PW-1:0] r_bin_nxt;
    logic [PW-1:0] rcnt_nxt;

    assign is_fwft = (mode_q == MODE_FWFT);

    // Decide whether a word leaves the RAM on this edge.
    always_comb begin
        if (is_fwft) pop = !ram_empty_q && (!ov_q || rd_en);
        else         pop = !ram_empty_q && rd_en;
        r_bin_nxt = r_bin + {{(PW-1){1'b0}}, pop};
        rcnt_nxt  = w_bin_s - r_bin_nxt;
    end

    // Mode latch: follows mode_sel only while reset is held.
    always_ff @(posedge rclk) begin
        if (!rst_n) mode_q <= rd_mode_e'(mode_sel);
    end

    // Pointer, output stage and registered read-domain flags.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            r_bin       <= '0;
            ram_empty_q <= 1'b1;
            ov_q        <= 1'b0;
            dout        <= '0;
            pae_n       <= 1'b0;
        end else begin
            r_bin       <= r_bin_nxt;
            ram_empty_q <= (rcnt_nxt == '0);
            pae_n       <= !(rcnt_nxt <= empty_ofs);
            if (pop)        dout <= ram_q;
            if (pop)        ov_q <= 1'b1;
            else if (rd_en) ov_q <= 1'b0;
        end
    end

    // Half-full clear: record a downward pass and the epoch it answers.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            r_drop  <= 1'b0;
            r_epoch <= 1'b0;
        end else if (pop && (rcnt_nxt <= HALF_CNT)) begin
            r_drop  <= 1'b1;
            r_epoch <= w_epoch_s;
        end
    end

    assign empty_n = is_fwft ? ov_q : !ram_empty_q;
endmodule

// File: rtl/dcf_fifo.sv
// Top level of the dual-clock FIFO with programmable flags.
// Wires the write side, read side, storage, offset registers and the
// pointer crossings together, and forms the half-full flag from one
// register in each domain.
// Assumes rst_n is held low across several edges of both clocks and that
// DEPTH is a power of two.
module dcf_fifo #(
    parameter int DW      = 9,
    parameter int DEPTH   = 16,
    parameter int BIG_OFS = 127,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    output logic          full_n,
    output logic          paf_n,
    input  logic          rd_en,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          pae_n,
    output logic          hf_n,
    input  logic          ofs_ld,
    input  logic [PW-1:0] ofs_full_in,
    input  logic [PW-1:0] ofs_empty_in
);
    logic [PW-1:0] w_bin, r_bin, w_bin_s, r_bin_s;
    logic [PW-1:0] full_ofs, empty_ofs;
    logic [DW-1:0] ram_q;
    logic          w_accept, w_idle, w_over, w_epoch, w_epoch_s;
    logic          r_drop, r_epoch, is_fwft;

    dcf_offsets #(.DEPTH(DEPTH), .BIG_OFS(BIG_OFS)) u_ofs (
        .wclk(wclk), .rst_n(rst_n), .ld(ofs_ld), .idle(w_idle),
        .full_in(ofs_full_in), .empty_in(ofs_empty_in),
        .full_ofs(full_ofs), .empty_ofs(empty_ofs)
    );

    dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .r_bin_s(r_bin_s),
        .full_ofs(full_ofs), .w_bin(w_bin), .w_accept(w_accept),
        .w_idle(w_idle), .full_n(full_n), .paf_n(paf_n),
        .w_over(w_over), .w_epoch(w_epoch)
    );

    dcf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(w_accept), .waddr(w_bin[AW-1:0]), .wdata(din),
        .raddr(r_bin[AW-1:0]), .rdata(ram_q)
    );

    dcf_ptr_xing #(.PW(PW)) u_w2r (
        .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
        .src_bin(w_bin), .dst_bin(w_bin_s)
    );

    dcf_ptr_xing #(.PW(PW)) u_r2w (
        .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n),
        .src_bin(r_bin), .dst_bin(r_bin_s)
    );

    dcf_ptr_xing #(.PW(1)) u_epoch (
        .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n),
        .src_bin(w_epoch), .dst_bin(w_epoch_s)
    );

    dcf_rd_side #(.DW(DW), .DEPTH(DEPTH)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .mode_sel(fwft_sel), .rd_en(rd_en),
        .w_bin_s(w_bin_s), .w_epoch_s(w_epoch_s), .empty_ofs(empty_ofs),
        .ram_q(ram_q), .r_bin(r_bin), .dout(dout), .empty_n(empty_n),
        .pae_n(pae_n), .r_drop(r_drop), .r_epoch(r_epoch), .is_fwft(is_fwft)
    );

    // Half-full: low while the write side is over half, unless the read
    // side has since passed back down in answer to the same crossing.
    assign hf_n = !(w_over && !(r_drop && (r_epoch == w_epoch)));
endmodule

// File: rtl/dcf_fifo_chk.sv
// Property checker for dcf_fifo, attached by the bind at the end of this file.
module dcf_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          paf_n,
    input logic          empty_n,
    input logic          pae_n,
    input logic          is_fwft,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] r_ptr
);
    // R7
    full_blocks_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && wr_en) |=> $stable(w_ptr));

    // R7
    full_implies_paf_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !paf_n);

    // R4
    paf_falls_on_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $fell(paf_n) |-> $past(wr_en));

    // R8
    empty_blocks_read_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!is_fwft && !empty_n && rd_en) |=> $stable(r_ptr));

    // R5
    empty_implies_pae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!is_fwft && !empty_n) |-> !pae_n);

    // R3
    fwft_valid_holds_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (is_fwft && empty_n && !rd_en) |=> empty_n);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH)) u_dcf_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .full_n(full_n), .paf_n(paf_n), .empty_n(empty_n), .pae_n(pae_n),
    .is_fwft(is_fwft), .w_ptr(w_bin), .r_ptr(r_bin)
);

// File: tb/tb_dcf_fifo.sv
module tb_dcf_fifo;
    localparam int WCLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 16;
    localparam int D  = 16;
    localparam int PW = $clog2(D) + 1;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst_n = 1'b0, fwft_sel = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ofs_ld = 1'b0;
    logic [8:0] din = '0;
    logic [PW-1:0] ofs_full_in = '0, ofs_empty_in = '0;
    logic full_n, paf_n, empty_n, pae_n, hf_n;
    logic [8:0] dout;

    int checks = 0, failures = 0, cap = D;
    logic [8:0] model[$];

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    dcf_fifo #(.DW(9), .DEPTH(D)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .wr_en(wr_en), .din(din), .full_n(full_n), .paf_n(paf_n),
        .rd_en(rd_en), .dout(dout), .empty_n(empty_n), .pae_n(pae_n),
        .hf_n(hf_n), .ofs_ld(ofs_ld), .ofs_full_in(ofs_full_in),
        .ofs_empty_in(ofs_empty_in)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge wclk);
        rst_n = 1'b0; fwft_sel = mode;
        repeat (6) @(negedge wclk);
        rst_n = 1'b1;
        model.delete();
        cap = mode ? D + 1 : D;
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wclk); wr_en = 1'b1; din = d;
        @(negedge wclk); wr_en = 1'b0;
        if (model.size() < cap) model.push_back(d);
    endtask

    task automatic pop_std();
        logic [8:0] e;
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        e = model.pop_front();
        chk("R2", "std read data", 16'(dout), 16'(e));
    endtask

    task automatic pop_fwft();
        @(negedge rclk);
        chk("R3", "fwft head data", 16'(dout), 16'(model[0]));
        chk("R3", "fwft valid before pop", 16'(empty_n), 16'd1);
        rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        void'(model.pop_front());
    endtask

    task automatic load_ofs(input logic [PW-1:0] m, input logic [PW-1:0] n,
                            input logic with_wr, input logic [8:0] d);
        @(negedge wclk);
        ofs_ld = 1'b1; ofs_full_in = m; ofs_empty_in = n;
        wr_en = with_wr; din = d;
        @(negedge wclk);
        ofs_ld = 1'b0; wr_en = 1'b0;
        if (with_wr) model.push_back(d);
    endtask

    // R1: reset values
    task automatic t_reset();
        do_reset(1'b0);
        @(negedge rclk);
        chk("R1", "full_n", 16'(full_n), 16'd1);
        chk("R1", "paf_n", 16'(paf_n), 16'd1);
        chk("R1", "hf_n", 16'(hf_n), 16'd1);
        chk("R1", "empty_n", 16'(empty_n), 16'd0);
        chk("R1", "pae_n", 16'(pae_n), 16'd0);
        chk("R1", "dout", 16'(dout), 16'd0);
    endtask

    // R2 R4 R5 R6 R7 R8 in standard mode
    task automatic t_std_flow();
        logic [8:0] last;
        for (int i = 1; i <= D; i++) begin
            push(9'(9'h100 + i));
            chk("R4", "std paf_n after write", 16'(paf_n), 16'(!(i >= D - 7)));
            chk("R6", "std hf_n after write", 16'(hf_n), 16'(!(i >= D/2 + 1)));
            chk("R7", "std full_n after write", 16'(full_n), 16'(!(i >= D)));
        end
        push(9'h0AA);                       // R7: dropped while full
        settle();
        chk("R5", "std pae_n when full", 16'(pae_n), 16'd1);
        for (int j = 1; j <= D; j++) begin
            pop_std();
            chk("R5", "std pae_n after read", 16'(pae_n), 16'(!(D - j <= 7)));
            @(negedge wclk);
            chk("R6", "std hf_n after read", 16'(hf_n), 16'(!(D - j > D/2)));
        end
        chk("R8", "std empty_n drained", 16'(empty_n), 16'd0);
        last = dout;
        @(negedge rclk); rd_en = 1'b1;      // R8: read while empty
        @(negedge rclk); rd_en = 1'b0;
        chk("R8", "dout kept on empty read", 16'(dout), 16'(last));
        push(9'h055);
        settle();
        pop_std();
    endtask

    // R6: write-set and read-clear of the half-full flag pending together
    task automatic t_hf_race();
        for (int i = 0; i < D/2; i++) push(9'(9'h020 + i));
        settle();
        chk("R6", "hf_n at exactly half", 16'(hf_n), 16'd1);
        push(9'h031);
        chk("R6", "hf_n set by write", 16'(hf_n), 16'd0);
        repeat (4) @(negedge rclk);
        pop_std();
        @(negedge wclk);
        chk("R6", "hf_n cleared by read edge", 16'(hf_n), 16'd1);
        settle();
        chk("R6", "hf_n stays high", 16'(hf_n), 16'd1);
        push(9'h032);
        chk("R6", "hf_n set again", 16'(hf_n), 16'd0);
        settle();
        while (model.size() > 0) pop_std();
        settle();
    endtask

    // R9: load coinciding with a write is refused; idle load takes effect
    task automatic t_offsets();
        load_ofs(5'd3, 5'd2, 1'b1, 9'h140);
        for (int i = 2; i <= D - 7; i++) begin
            push(9'(9'h140 + i));
            chk("R9", "paf_n keeps default m", 16'(paf_n), 16'(!(i >= D - 7)));
        end
        settle();
        while (model.size() > 0) pop_std();
        settle();
        load_ofs(5'd3, 5'd2, 1'b0, 9'h000);
        for (int i = 1; i <= D - 3; i++) begin
            push(9'(9'h160 + i));
            chk("R4", "paf_n with loaded m", 16'(paf_n), 16'(!(i >= D - 3)));
        end
        settle();
        for (int j = 1; j <= D - 3; j++) begin
            pop_std();
            chk("R5", "pae_n with loaded n", 16'(pae_n), 16'(!(D - 3 - j <= 2)));
        end
        settle();
    endtask

    // R3 R4 R5 R6 R7 R8 R9 in fall-through mode
    task automatic t_fwft();
        logic [8:0] last;
        do_reset(1'b1);
        @(negedge rclk);
        chk("R3", "fwft valid low after reset", 16'(empty_n), 16'd0);
        push(9'h1F0);
        repeat (6) @(negedge rclk);
        chk("R3", "first word falls through", 16'(dout), 16'h1F0);
        chk("R3", "valid without strobe", 16'(empty_n), 16'd1);
        repeat (4) @(negedge wclk);
        for (int i = 2; i <= D + 1; i++) begin
            push(9'(9'h1F0 + i));
            chk("R4", "fwft paf_n (default m, R9)", 16'(paf_n), 16'(!(i >= D + 1 - 7)));
            chk("R6", "fwft hf_n after write", 16'(hf_n), 16'(!(i >= D/2 + 2)));
            chk("R7", "fwft full_n after write", 16'(full_n), 16'(!(i >= D + 1)));
        end
        push(9'h0BB);                       // R7: dropped while full
        settle();
        chk("R5", "fwft pae_n when full", 16'(pae_n), 16'd1);
        for (int j = 1; j <= D + 1; j++) begin
            pop_fwft();
            chk("R5", "fwft pae_n after pop", 16'(pae_n), 16'(!(D + 1 - j <= 8)));
            @(negedge wclk);
            chk("R6", "fwft hf_n after pop", 16'(hf_n), 16'(D + 1 - j <= D/2 + 1));
        end
        @(negedge rclk);
        chk("R3", "fwft valid low when drained", 16'(empty_n), 16'd0);
        last = dout;
        @(negedge rclk); rd_en = 1'b1;      // R8: read while empty
        @(negedge rclk); rd_en = 1'b0;
        chk("R8", "fwft dout kept", 16'(dout), 16'(last));
        push(9'h077);
        settle();
        chk("R8", "fwft next word after empty read", 16'(dout), 16'h077);
    endtask

    initial begin
        t_reset();
        t_std_flow();
        t_hf_race();
        t_offsets();
        t_fwft();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(WCLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule